// File: doc/BRIEF.md
# Descriptor Ring Queue Walker

This block moves data for one endpoint direction by following a linked ring of 16-byte descriptors in memory. It is started with a ring address. It reads the four words of the current descriptor and checks that it owns it, optionally validates a byte checksum, and then carries out the data move. For transmit, it reads the buffer and sends bytes on a stream toward the endpoint FIFO. For receive, it takes bytes from the FIFO stream and stores them in the buffer. After the move it writes status back, gives ownership of the descriptor back to software, and follows the link to the next descriptor.

Each descriptor uses little-endian fields. Word 0 holds the flag byte (bit 0 owned by hardware, bit 2 skip, bit 7 interrupt on completion), the checksum byte and the receive capacity in bytes 2-3. Word 1 is the link to the next descriptor. Word 2 is the buffer byte address. Word 3 holds the transmit length, or the received total written back on receive, in bytes 12-13, and the extended flags in byte 15. The direction is fixed per instance by a parameter. Memory is reached through a single word-wide request/acknowledge port.

When the engine meets a descriptor it does not own, it parks on it until software gives a resume strobe. When a checksum fails, the engine halts until it is restarted with a new start strobe.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset the engine is idle: no memory request, no stream beat offered, receive ready low, both interrupt outputs low.
- R2: A start strobe loads the start address into the current pointer and begins reading the descriptor's four words at that address, lowest word first. Start is accepted only when idle, parked or halted.
- R3: A fetched descriptor with flag bit 0 clear causes no data movement and no memory write. The current pointer stays on it until a resume strobe, which makes the engine read it again.
- R4: With checksum checking enabled, an owned descriptor whose 16 bytes do not sum to 0xFF (mod 256) raises a one-cycle checksum interrupt. The engine then halts with no writes, keeping the pointer, and ignores resume until a start strobe. With checking disabled the checksum byte has no effect.
- R5: An owned descriptor with flag bit 2 set is skipped: no data is moved, no write is made to it, no completion interrupt is raised, and the engine continues at its link address.
- R6: On transmit, the engine sends the number of bytes given in bytes 12-13, in address order from the buffer address, which may be unaligned. Last is marked on the final data byte, unless a zero-length packet follows.
- R7: On transmit, extended-flag bit 5 (bit 29 of word 3) adds one beat with the zero-length marker and last set after the data. A length of 0 with this bit set gives only that beat.
- R8: On receive, the engine accepts bytes until one marked last or until the capacity in bytes 2-3 is reached. It then drops ready and stores each byte at buffer address plus index using byte enables. It writes the count into bytes 12-13 and keeps bytes 14-15.
- R9: On completion the engine writes word 0 back with only bit 0 cleared. This ownership write is the last write for that descriptor. The engine then continues at the link address in bytes 4-7.
- R10: A one-cycle completion interrupt follows the ownership write only when flag bit 7 is set.
- R11: A memory request keeps its address, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_start | input | 1 | Start strobe, loads q_start_addr |
| q_start_addr | input | 32 | Ring start address |
| q_resume | input | 1 | Re-read a parked descriptor |
| csum_en | input | 1 | Enable descriptor checksum check |
| cur_ptr | output | 32 | Address of the current descriptor |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_csum_err | output | 1 | Checksum failure interrupt pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_be | output | 4 | Byte enables for writes |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Transmit beat offered |
| tx_ready | input | 1 | Transmit beat taken |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final beat of the descriptor |
| tx_zlp | output | 1 | Beat is a zero-length packet marker |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte accepted |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Receive byte ends the packet |

## Verification
Transmit is tried with an aligned six-byte buffer under a stalling ready, with an unaligned three-byte buffer, and with a zero-length descriptor. Together these separate byte-lane selection, last-marker placement and the extra zero-length beat. Receive is tried once with a packet that ends early and once with a source that offers more than the capacity. This tells a stop on the last marker apart from a stop on a full buffer, and shows whether the bytes beside the length field survive. Skipped, unowned and bad-checksum descriptors are chained in front of good ones. Counting memory writes and interrupts then shows that each of these paths leaves memory untouched and resumes only on its own strobe.

// File: rtl/desc_ring_walker.sv
`timescale 1ns/1ps
module desc_ring_walker #(
  parameter bit IS_TX = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        q_start,
  input  logic [31:0] q_start_addr,
  input  logic        q_resume,
  input  logic        csum_en,
  output logic [31:0] cur_ptr,
  output logic        irq_done,
  output logic        irq_csum_err,
  output logic        mem_req,
  output logic        mem_we,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_zlp,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last
);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_EVAL, S_TXCHK, S_TXRD, S_TXOUT, S_ZLP,
    S_RXIN, S_RXWR, S_WB3, S_WB0, S_WAITOWN, S_HALT
  } st_t;

  st_t         st;
  logic [31:0] ptr;
  logic [31:0] dw [4];
  logic [1:0]  widx;
  logic [15:0] cnt;
  logic [7:0]  byte_q;
  logic        last_q;
  logic [7:0]  sum8;
  logic [31:0] baddr;
  logic [31:0] lane_word;
  logic        own, bps, ioc, zlp, restart;
  logic [15:0] rxlim, txlen;

  assign own   = dw[0][0];
  assign bps   = dw[0][2];
  assign ioc   = dw[0][7];
  assign rxlim = dw[0][31:16];
  assign txlen = dw[3][15:0];
  assign zlp   = dw[3][29];
  assign baddr = dw[2] + {16'd0, cnt};
  assign lane_word = mem_rdata >> {baddr[1:0], 3'b000};

  always_comb begin
    sum8 = 8'd0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        sum8 = sum8 + dw[i][8*j +: 8];
  end

  assign cur_ptr  = ptr;
  assign mem_req  = st inside {S_FETCH, S_TXRD, S_RXWR, S_WB3, S_WB0};
  assign mem_we   = st inside {S_RXWR, S_WB3, S_WB0};
  assign mem_be   = (st == S_RXWR) ? (4'b0001 << baddr[1:0]) : 4'hF;
  assign tx_valid = (st == S_TXOUT) || (st == S_ZLP);
  assign tx_data  = (st == S_TXOUT) ? byte_q : 8'd0;
  assign tx_zlp   = (st == S_ZLP);
  assign tx_last  = (st == S_ZLP) || ((st == S_TXOUT) && (cnt == txlen - 16'd1) && !zlp);
  assign rx_ready = (st == S_RXIN) && (cnt != rxlim);
  assign restart  = q_start && (st inside {S_IDLE, S_WAITOWN, S_HALT});

  always_comb begin
    case (st)
      S_FETCH:        mem_addr = ptr + {28'd0, widx, 2'b00};
      S_TXRD, S_RXWR: mem_addr = {baddr[31:2], 2'b00};
      S_WB3:          mem_addr = ptr + 32'd12;
      default:        mem_addr = ptr;
    endcase
  end

  always_comb begin
    case (st)
      S_RXWR:  mem_wdata = {4{byte_q}};
      S_WB3:   mem_wdata = {dw[3][31:16], cnt};
      S_WB0:   mem_wdata = {dw[0][31:1], 1'b0};
      default: mem_wdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ptr <= 32'd0;
      widx <= 2'd0;
      cnt <= 16'd0;
      byte_q <= 8'd0;
      last_q <= 1'b0;
      irq_done <= 1'b0;
      irq_csum_err <= 1'b0;
      for (int i = 0; i < 4; i++) dw[i] <= 32'd0;
    end else begin
      irq_done <= 1'b0;
      irq_csum_err <= 1'b0;
      if (restart) begin
        ptr  <= q_start_addr;
        widx <= 2'd0;
        st   <= S_FETCH;
      end else begin
        case (st)
          S_FETCH: if (mem_ack) begin
            dw[widx] <= mem_rdata;
            widx <= widx + 2'd1;
            if (widx == 2'd3) st <= S_EVAL;
          end
          S_EVAL: begin
            cnt <= 16'd0;
            if (!own) st <= S_WAITOWN;
            else if (csum_en && sum8 != 8'hFF) begin
              irq_csum_err <= 1'b1;
              st <= S_HALT;
            end else if (bps) begin
              ptr <= dw[1];
              st <= S_FETCH;
            end else st <= IS_TX ? S_TXCHK : S_RXIN;
          end
          S_TXCHK:
            if (cnt != txlen) st <= S_TXRD;
            else if (zlp)     st <= S_ZLP;
            else              st <= S_WB0;
          S_TXRD: if (mem_ack) begin
            byte_q <= lane_word[7:0];
            st <= S_TXOUT;
          end
          S_TXOUT: if (tx_ready) begin
            cnt <= cnt + 16'd1;
            st <= S_TXCHK;
          end
          S_ZLP: if (tx_ready) st <= S_WB0;
          S_RXIN:
            if (cnt == rxlim) st <= S_WB3;
            else if (rx_valid) begin
              byte_q <= rx_data;
              last_q <= rx_last;
              st <= S_RXWR;
            end
          S_RXWR: if (mem_ack) begin
            cnt <= cnt + 16'd1;
            st <= last_q ? S_WB3 : S_RXIN;
          end
          S_WB3: if (mem_ack) st <= S_WB0;
          S_WB0: if (mem_ack) begin
            irq_done <= ioc;
            ptr <= dw[1];
            widx <= 2'd0;
            st <= S_FETCH;
          end
          S_WAITOWN: if (q_resume) begin
            widx <= 2'd0;
            st <= S_FETCH;
          end
          default: ;
        endcase
      end
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> $past(mem_req && mem_we && mem_ack));

  a_r4_halt_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    irq_csum_err |-> !mem_req && !tx_valid && !rx_ready);

  a_r4_halt_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    irq_csum_err && !q_start |=> $stable(cur_ptr));

  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_zlp));

  a_r10_irq_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_csum_err));

endmodule

// File: tb/desc_ring_walker_tb_top.sv
`timescale 1ns/1ps
module drw_mem_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [3:0]  be,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  input  logic        pk_en,
  input  logic [31:0] pk_addr,
  input  logic [31:0] pk_data,
  output int          wcount
);
  logic [31:0] m [0:1023];
  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      wcount <= 0;
      rdata <= 32'd0;
    end else begin
      ack <= req && !ack;
      if (req && !ack) begin
        rdata <= m[addr[11:2]];
        if (we) begin
          for (int b = 0; b < 4; b++)
            if (be[b]) m[addr[11:2]][8*b +: 8] <= wdata[8*b +: 8];
          wcount <= wcount + 1;
        end
      end
    end
    if (pk_en) m[pk_addr[11:2]] <= pk_data;
  end
endmodule

module desc_ring_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int nchecks = 0, nfail = 0, cyc = 0;

  logic t_start = 0, t_resume = 0, t_csum = 0;
  logic [31:0] t_saddr = 0;
  logic [31:0] t_ptr;
  logic t_done, t_cerr, t_req, t_we, t_ack;
  logic [3:0] t_be;
  logic [31:0] t_addr, t_wdata, t_rdata;
  logic t_txv, t_txr = 1'b1, t_txl, t_txz, t_rxr_unused;
  logic [7:0] t_txd;
  logic t_pk = 0; logic [31:0] t_pka = 0, t_pkd = 0; int t_wc;

  logic r_start = 0, r_resume = 0, r_csum = 0;
  logic [31:0] r_saddr = 0;
  logic [31:0] r_ptr;
  logic r_done, r_cerr, r_req, r_we, r_ack;
  logic [3:0] r_be;
  logic [31:0] r_addr, r_wdata, r_rdata;
  logic r_txv_unused, r_txl_unused, r_txz_unused;
  logic [7:0] r_txd_unused;
  logic r_rxv = 0, r_rxr, r_rxl = 0;
  logic [7:0] r_rxd = 0;
  logic r_pk = 0; logic [31:0] r_pka = 0, r_pkd = 0; int r_wc;

  desc_ring_walker #(.IS_TX(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .q_start(t_start), .q_start_addr(t_saddr), .q_resume(t_resume),
    .csum_en(t_csum), .cur_ptr(t_ptr), .irq_done(t_done), .irq_csum_err(t_cerr),
    .mem_req(t_req), .mem_we(t_we), .mem_be(t_be), .mem_addr(t_addr), .mem_wdata(t_wdata),
    .mem_ack(t_ack), .mem_rdata(t_rdata), .tx_valid(t_txv), .tx_ready(t_txr), .tx_data(t_txd),
    .tx_last(t_txl), .tx_zlp(t_txz), .rx_valid(1'b0), .rx_ready(t_rxr_unused), .rx_data(8'd0),
    .rx_last(1'b0));

  desc_ring_walker #(.IS_TX(1'b0)) dut_rx_i (
    .clk(clk), .rst_n(rst_n), .q_start(r_start), .q_start_addr(r_saddr), .q_resume(r_resume),
    .csum_en(r_csum), .cur_ptr(r_ptr), .irq_done(r_done), .irq_csum_err(r_cerr),
    .mem_req(r_req), .mem_we(r_we), .mem_be(r_be), .mem_addr(r_addr), .mem_wdata(r_wdata),
    .mem_ack(r_ack), .mem_rdata(r_rdata), .tx_valid(r_txv_unused), .tx_ready(1'b1),
    .tx_data(r_txd_unused), .tx_last(r_txl_unused), .tx_zlp(r_txz_unused), .rx_valid(r_rxv),
    .rx_ready(r_rxr), .rx_data(r_rxd), .rx_last(r_rxl));

  drw_mem_model mem_t_i (.clk(clk), .rst_n(rst_n), .req(t_req), .we(t_we), .be(t_be),
    .addr(t_addr), .wdata(t_wdata), .ack(t_ack), .rdata(t_rdata), .pk_en(t_pk),
    .pk_addr(t_pka), .pk_data(t_pkd), .wcount(t_wc));
  drw_mem_model mem_r_i (.clk(clk), .rst_n(rst_n), .req(r_req), .we(r_we), .be(r_be),
    .addr(r_addr), .wdata(r_wdata), .ack(r_ack), .rdata(r_rdata), .pk_en(r_pk),
    .pk_addr(r_pka), .pk_data(r_pkd), .wcount(r_wc));

  // monitors, sampled at the falling edge
  logic [7:0] bdat [64];
  bit blast [64];
  bit bzlp [64];
  int nb = 0, t_ndone = 0, t_nerr = 0, r_ndone = 0, r_nerr = 0, viol = 0;
  bit ready_alt = 0;
  bit t_pend = 0, r_pend = 0;
  logic [31:0] t_paddr = 0, r_paddr = 0;

  always @(negedge clk) begin
    t_txr = ready_alt ? ~t_txr : 1'b1;
    if (t_txv && t_txr && nb < 64) begin
      bdat[nb] = t_txd; blast[nb] = t_txl; bzlp[nb] = t_txz; nb++;
    end
    if (t_done) t_ndone++;
    if (t_cerr) t_nerr++;
    if (r_done) r_ndone++;
    if (r_cerr) r_nerr++;
    if (t_pend && (!t_req || t_addr != t_paddr)) viol++;
    if (r_pend && (!r_req || r_addr != r_paddr)) viol++;
    t_pend = t_req && !t_ack; t_paddr = t_addr;
    r_pend = r_req && !r_ack; r_paddr = r_addr;
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  task automatic poke(input bit rx, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    if (rx) begin r_pk = 1; r_pka = a; r_pkd = d; end
    else begin t_pk = 1; t_pka = a; t_pkd = d; end
    @(negedge clk);
    r_pk = 0; t_pk = 0;
  endtask

  function automatic logic [7:0] fix_sum(input logic [31:0] w0, w1, w2, w3);
    logic [7:0] s = 8'd0;
    logic [31:0] w [4];
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (!(i == 0 && j == 1)) s = s + w[i][8*j +: 8];
    return 8'hFF - s;
  endfunction

  task automatic put_desc(input bit rx, input logic [31:0] a, input logic [7:0] flags,
      input logic [7:0] cs, input logic [15:0] rxlen, input logic [31:0] nxt,
      input logic [31:0] bufa, input logic [31:0] w3);
    poke(rx, a, {rxlen, cs, flags});
    poke(rx, a + 4, nxt);
    poke(rx, a + 8, bufa);
    poke(rx, a + 12, w3);
  endtask

  task automatic start_tx(input logic [31:0] a);
    @(negedge clk); t_start = 1; t_saddr = a;
    @(negedge clk); t_start = 0;
    chk("R2", "tx ptr after start", t_ptr, a);
    chk("R2", "tx first fetch addr", {t_req, t_we, t_addr[29:0]}, {2'b10, a[29:0]});
  endtask

  task automatic start_rx(input logic [31:0] a);
    @(negedge clk); r_start = 1; r_saddr = a;
    @(negedge clk); r_start = 0;
    chk("R2", "rx ptr after start", r_ptr, a);
  endtask

  task automatic wait_ptr(input bit rx, input logic [31:0] a);
    for (int k = 0; k < 3000; k++) begin
      if ((rx ? r_ptr : t_ptr) == a) break;
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic rx_push(input logic [7:0] b, input bit last, output bit took);
    @(negedge clk);
    r_rxv = 1; r_rxd = b; r_rxl = last; took = 0;
    for (int k = 0; k < 40; k++) begin
      if (r_rxr) begin took = 1; break; end
      @(negedge clk);
    end
    if (took) @(posedge clk);
  endtask

  task automatic rx_stop();
    @(negedge clk); r_rxv = 0; r_rxl = 0;
  endtask

  // scenarios
  task automatic t_reset();
    chk("R1", "tx mem_req", t_req, 1'b0);
    chk("R1", "tx valid", t_txv, 1'b0);
    chk("R1", "rx ready", r_rxr, 1'b0);
    chk("R1", "irqs", {t_done, t_cerr, r_done, r_cerr}, 4'd0);
  endtask

  task automatic t_tx_basic();
    int b0 = nb, d0 = t_ndone, w0 = t_wc;
    poke(0, 32'h1E0, 32'h0);
    poke(0, 32'h400, 32'h44332211);
    poke(0, 32'h404, 32'h88776655);
    // checksum byte 0x00 is wrong, but checking is disabled (R4)
    put_desc(0, 32'h100, 8'h81, 8'h00, 16'hBEEF, 32'h1E0, 32'h400, 32'h00000006);
    ready_alt = 1;
    start_tx(32'h100);
    wait_ptr(0, 32'h1E0);
    ready_alt = 0;
    chk("R6", "beat count", nb - b0, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R6", "tx byte", bdat[b0+i], 8'h11 * (i + 1));
      chk("R6", "last mark", blast[b0+i], i == 5);
    end
    chk("R4", "bad csum ignored when disabled", t_nerr, 0);
    chk("R10", "done irq with ioc", t_ndone - d0, 1);
    chk("R9", "word0 writeback", mem_t_i.m[32'h100 >> 2], 32'hBEEF0080);
    chk("R9", "tx makes one write", t_wc - w0, 1);
    chk("R9", "follows link", t_ptr, 32'h1E0);
  endtask

  task automatic t_tx_zlp();
    int b0 = nb, d0 = t_ndone;
    poke(0, 32'h500, 32'hDDCCBBAA);
    put_desc(0, 32'h120, 8'h01, 8'h00, 16'h0, 32'h140, 32'h501, 32'h20000003);
    put_desc(0, 32'h140, 8'h01, 8'h00, 16'h0, 32'h1E0, 32'h501, 32'h20000000);
    start_tx(32'h120);
    wait_ptr(0, 32'h1E0);
    chk("R7", "beat count", nb - b0, 5);
    chk("R6", "unaligned bytes", {bdat[b0], bdat[b0+1], bdat[b0+2]}, 24'hBBCCDD);
    chk("R7", "no last before zlp", blast[b0+2], 1'b0);
    chk("R7", "zlp beat", {bzlp[b0+2], bzlp[b0+3], blast[b0+3]}, 3'b011);
    chk("R7", "zero-length desc gives only zlp", {bzlp[b0+4], blast[b0+4]}, 2'b11);
    chk("R10", "no irq without ioc", t_ndone - d0, 0);
    chk("R9", "second desc released", mem_t_i.m[32'h140 >> 2], 32'h00000000);
  endtask

  task automatic t_bypass();
    int b0 = nb, d0 = t_ndone, w0 = t_wc;
    poke(0, 32'h600, 32'h000000EE);
    put_desc(0, 32'h160, 8'h85, 8'h00, 16'h0, 32'h180, 32'h500, 32'h00000004);
    put_desc(0, 32'h180, 8'h81, 8'h00, 16'h0, 32'h1E0, 32'h600, 32'h00000001);
    start_tx(32'h160);
    wait_ptr(0, 32'h1E0);
    chk("R5", "only next desc data", {nb - b0, 24'(bdat[b0])}, {32'd1, 24'hEE});
    chk("R5", "skipped desc untouched", mem_t_i.m[32'h160 >> 2], 32'h00000085);
    chk("R5", "single writeback", t_wc - w0, 1);
    chk("R5", "irq only from served desc", t_ndone - d0, 1);
  endtask

  task automatic t_unowned();
    int b0 = nb, w0 = t_wc;
    put_desc(0, 32'h1A0, 8'h00, 8'h00, 16'h0, 32'h1E0, 32'h600, 32'h00000002);
    start_tx(32'h1A0);
    repeat (60) @(negedge clk);
    chk("R3", "no beats while unowned", nb - b0, 0);
    chk("R3", "no writes while unowned", t_wc - w0, 0);
    chk("R3", "ptr parked", t_ptr, 32'h1A0);
    poke(0, 32'h1A0, 32'h00000081);
    @(negedge clk); t_resume = 1;
    @(negedge clk); t_resume = 0;
    wait_ptr(0, 32'h1E0);
    chk("R3", "served after resume", nb - b0, 2);
    chk("R3", "bytes after resume", {bdat[b0], bdat[b0+1]}, 16'hEE00);
  endtask

  task automatic t_checksum();
    int b0 = nb, d0 = t_ndone, e0 = t_nerr, w0 = t_wc;
    logic [7:0] good;
    good = fix_sum(32'h00000081, 32'h1E0, 32'h600, 32'h00000001);
    t_csum = 1;
    put_desc(0, 32'h1C0, 8'h81, good + 8'd1, 16'h0, 32'h1E0, 32'h600, 32'h00000001);
    start_tx(32'h1C0);
    repeat (40) @(negedge clk);
    chk("R4", "csum irq", t_nerr - e0, 1);
    chk("R4", "halt keeps ptr", t_ptr, 32'h1C0);
    chk("R4", "no writes on bad csum", t_wc - w0, 0);
    @(negedge clk); t_resume = 1;
    @(negedge clk); t_resume = 0;
    repeat (40) @(negedge clk);
    chk("R4", "resume ignored while halted", {nb - b0, t_wc - w0}, 64'd0);
    poke(0, 32'h1C0, {16'h0, good, 8'h81});
    start_tx(32'h1C0);
    wait_ptr(0, 32'h1E0);
    chk("R4", "good csum passes", {nb - b0, 24'(bdat[b0])}, {32'd1, 24'hEE});
    chk("R4", "one irq each", {t_ndone - d0, t_nerr - e0}, {32'd1, 32'd1});
    t_csum = 0;
  endtask

  task automatic t_rx_last();
    int d0 = r_ndone, w0 = r_wc;
    bit took;
    poke(1, 32'h1E0, 32'h0);
    poke(1, 32'h400, 32'h11111111);
    poke(1, 32'h404, 32'h11111111);
    poke(1, 32'h408, 32'h11111111);
    put_desc(1, 32'h100, 8'h81, 8'h00, 16'd8, 32'h1E0, 32'h402, 32'hA55AFFFF);
    start_rx(32'h100);
    for (int i = 1; i <= 5; i++) rx_push(8'(i), i == 5, took);
    rx_stop();
    wait_ptr(1, 32'h1E0);
    chk("R8", "word 0x400", mem_r_i.m[32'h400 >> 2], 32'h02011111);
    chk("R8", "word 0x404", mem_r_i.m[32'h404 >> 2], 32'h11050403);
    chk("R8", "word 0x408 untouched", mem_r_i.m[32'h408 >> 2], 32'h11111111);
    chk("R8", "count written, 14-15 kept", mem_r_i.m[32'h10C >> 2], 32'hA55A0005);
    chk("R9", "rx ownership cleared", mem_r_i.m[32'h100 >> 2], 32'h00080080);
    chk("R9", "rx write total", r_wc - w0, 7);
    chk("R10", "rx done irq", r_ndone - d0, 1);
  endtask

  task automatic t_rx_full();
    int d0 = r_ndone, acc = 0;
    bit took;
    poke(1, 32'h500, 32'h0);
    poke(1, 32'h504, 32'h0);
    put_desc(1, 32'h120, 8'h01, 8'h00, 16'd3, 32'h1E0, 32'h500, 32'h00000000);
    start_rx(32'h120);
    for (int i = 0; i < 5; i++) begin
      rx_push(8'hA1 + 8'(i), 1'b0, took);
      if (took) acc++;
    end
    rx_stop();
    wait_ptr(1, 32'h1E0);
    chk("R8", "accepted up to capacity", acc, 3);
    chk("R8", "buffer words", mem_r_i.m[32'h500 >> 2], 32'h00A3A2A1);
    chk("R8", "no overrun", mem_r_i.m[32'h504 >> 2], 32'h0);
    chk("R8", "count at capacity", mem_r_i.m[32'h12C >> 2], 32'h00000003);
    chk("R10", "no irq without ioc", r_ndone - d0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_zlp();
    t_bypass();
    t_unowned();
    t_checksum();
    t_rx_last();
    t_rx_full();
    chk("R11", "request held until ack", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule